// File: doc/BRIEF.md
# Configuration Bitstream Streamer

This block is the read side of a configuration memory. It holds several stored images in a small on-chip ROM and plays one of them out to a programmable-logic target. The target provides the clock. The stream can leave in one of two forms. In serial form it is one bit per clock on the lowest data line. In byte form it is a whole byte per clock on eight lines, and in that form a busy input from the target holds the stream in place.

The ROM is divided into equal regions, one per stored revision. A two-bit revision number picks the region. It comes either from external pins or from an internal register, and a source-select input chooses between them. The revision and the stream form are captured while the output-enable/reset input is low, so they stay fixed for the whole stream. When the last byte of the region has been taken, a cascade-enable output goes high so that a following device can continue the image. The ROM has a plain write port so that a bench or boot loader can fill it.

Top module: `cfg_streamer`

## Requirements
- R1: `dout` is zero in every cycle unless `chip_en`, `out_en` and `cfg_req` were all high at the previous rising edge. Data first appears one edge after all three are high.
- R2: In serial mode (`byte_mode` = 0), only `dout[0]` carries data and `dout[7:1]` stay zero. Each byte goes out most significant bit first, one bit per clock.
- R3: In byte mode (`byte_mode` = 1), one stored byte per clock appears on `dout[7:0]`. The stream starts at offset 0 of the selected region on the first clock after the enables are high.
- R4: In byte mode, `busy` high at a rising edge keeps the current byte on `dout`. In serial mode `busy` has no effect.
- R5: Revision r occupies ROM addresses r*16 to r*16+15; the revision forms address bits [5:4] and the offset forms bits [3:0]. The edge that consumes offset 15 raises `cascade_en`. While `cascade_en` is high, `dout` is zero and the stream does not move.
- R6: `rst` high or `out_en` low at a rising edge clears `cascade_en` and `dout` after that edge. It also returns the read position to offset 0 of the selected revision.
- R7: With `rev_ext_sel` = 1 the revision comes from `rev_pins`. With `rev_ext_sel` = 0 it comes from an internal register, which `rev_reg_we` loads from `rev_reg_d` and `rst` clears to 0.
- R8: The revision and the stream mode are captured at every rising edge where `out_en` is low. Changing pins, source select or mode while `out_en` is high has no effect until the next such edge.
- R9: Pulling `chip_en` or `cfg_req` low pauses the stream without losing its place. On resume, the same item is presented again.
- R10: In serial mode, the byte address advances only after all eight bits of the current byte have been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Device select, high active |
| out_en | input | 1 | Output enable; low holds the stream at its start |
| cfg_req | input | 1 | Configuration request from the target, high active |
| busy | input | 1 | Target busy; stalls the byte stream |
| byte_mode | input | 1 | 1 = byte form, 0 = serial form |
| rev_ext_sel | input | 1 | 1 = revision from pins, 0 = from internal register |
| rev_pins | input | 2 | External revision number |
| rev_reg_we | input | 1 | Load strobe for the internal revision register |
| rev_reg_d | input | 2 | Value for the internal revision register |
| rom_we | input | 1 | ROM write strobe |
| rom_waddr | input | 6 | ROM write address |
| rom_wdata | input | 8 | ROM write data |
| dout | output | 8 | Stream data; only bit 0 used in serial form |
| cascade_en | output | 1 | High once the selected region is exhausted |

## Verification
The assertions check, on every cycle, the rules that need no knowledge of the stored content:
- `dout` stays quiet when the enables were not all high, and while `cascade_en` is high.
- The upper lines stay zero in serial form.
- A busy stall in byte form freezes the read position.
- `cascade_en` rises only after the region offset has wrapped to zero.
- The captured revision stays fixed while `out_en` is high.

Only the bench's scenarios can show the content-dependent behaviours. These are:
- The correct byte and bit order for each revision source.
- Resuming on the same item after a pause.
- Revision changes being deferred until the next reset.
- Busy having no effect in serial form.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_BYTE   = 1'b1
  } stream_mode_e;
endpackage

// File: rtl/cfgs_rom.sv
module cfgs_rom #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfgs_rev_sel.sv
module cfgs_rev_sel
  import cfgs_pkg::*;
#(
  parameter int REV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             out_en,
  input  logic             ext_sel,
  input  logic [REV_W-1:0] pins,
  input  logic             reg_we,
  input  logic [REV_W-1:0] reg_d,
  input  stream_mode_e     mode_in,
  output logic [REV_W-1:0] rev_nxt,
  output logic [REV_W-1:0] rev_q,
  output stream_mode_e     mode_q
);
  logic [REV_W-1:0] ireg_q;
  logic [REV_W-1:0] sel;
  logic             capture;
  stream_mode_e     mode_nxt;

  always_ff @(posedge clk) begin
    if (rst)         ireg_q <= '0;
    else if (reg_we) ireg_q <= reg_d;
  end

  assign sel      = ext_sel ? pins : ireg_q;
  assign capture  = rst | ~out_en;
  assign rev_nxt  = capture ? sel : rev_q;
  assign mode_nxt = capture ? mode_in : mode_q;

  always_ff @(posedge clk) begin
    rev_q  <= rev_nxt;
    mode_q <= mode_nxt;
  end

  // R8: selection frozen for the duration of a stream
  p_rev_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    out_en |=> ($stable(rev_q) && $stable(mode_q)));
endmodule

// File: rtl/cfgs_addr_ctl.sv
module cfgs_addr_ctl #(
  parameter int REV_W = 2,
  parameter int OFS_W = 4,
  parameter int BIT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   out_en,
  input  logic                   active,
  input  logic                   wide,
  input  logic                   busy,
  input  logic [REV_W-1:0]       rev_nxt,
  output logic [REV_W+OFS_W-1:0] addr_nxt,
  output logic [REV_W+OFS_W-1:0] addr_q,
  output logic [BIT_W-1:0]       bit_q,
  output logic                   drive_q,
  output logic                   casc_q
);
  logic [BIT_W-1:0] bit_nxt;
  logic             drive_nxt, casc_nxt;
  logic             hold, adv, byte_done, last;
  logic [OFS_W-1:0] ofs;

  assign ofs       = addr_q[OFS_W-1:0];
  assign hold      = rst | ~out_en;
  assign adv       = drive_q & active & ~casc_q & ~(wide & busy);
  assign byte_done = wide | (bit_q == '1);
  assign last      = (ofs == '1);

  always_comb begin
    addr_nxt  = addr_q;
    bit_nxt   = bit_q;
    drive_nxt = drive_q;
    casc_nxt  = casc_q;
    if (hold) begin
      addr_nxt  = {rev_nxt, {OFS_W{1'b0}}};
      bit_nxt   = '0;
      drive_nxt = 1'b0;
      casc_nxt  = 1'b0;
    end else begin
      drive_nxt = active;
      if (adv) begin
        if (byte_done) begin
          bit_nxt  = '0;
          addr_nxt = {addr_q[REV_W+OFS_W-1:OFS_W],
                      last ? {OFS_W{1'b0}} : OFS_W'(ofs + 1'b1)};
          casc_nxt = last;
        end else begin
          bit_nxt = BIT_W'(bit_q + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr_nxt;
    bit_q   <= bit_nxt;
    drive_q <= drive_nxt;
    casc_q  <= casc_nxt;
  end

  // R4: a busy stall in byte form freezes the read position
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (out_en && wide && busy) |=> ($stable(addr_q) && $stable(bit_q)));
  // R5: the cascade hand-off happens exactly at the region wrap
  p_casc_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(casc_q) |-> (addr_q[OFS_W-1:0] == '0));
  // R6: output enable low clears drive and cascade
  p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (!casc_q && !drive_q && bit_q == '0));
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfgs_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int REV_W        = 2,
  parameter int REGION_DEPTH = 16,
  parameter int AW           = REV_W + $clog2(REGION_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              cfg_req,
  input  logic              busy,
  input  logic              byte_mode,
  input  logic              rev_ext_sel,
  input  logic [REV_W-1:0]  rev_pins,
  input  logic              rev_reg_we,
  input  logic [REV_W-1:0]  rev_reg_d,
  input  logic              rom_we,
  input  logic [AW-1:0]     rom_waddr,
  input  logic [DATA_W-1:0] rom_wdata,
  output logic [DATA_W-1:0] dout,
  output logic              cascade_en
);
  localparam int OFS_W = $clog2(REGION_DEPTH);
  localparam int BIT_W = $clog2(DATA_W);

  logic               active;
  logic [REV_W-1:0]   rev_nxt, rev_q;
  stream_mode_e       mode_q, mode_in;
  logic [AW-1:0]      addr_nxt, addr_q;
  logic [BIT_W-1:0]   bit_q;
  logic               drive_q, casc_q;
  logic [DATA_W-1:0]  rom_q, shifted;

  assign active  = chip_en & out_en & cfg_req;
  assign mode_in = byte_mode ? MODE_BYTE : MODE_SERIAL;

  cfgs_rev_sel #(.REV_W(REV_W)) u_rev (
    .clk(clk), .rst(rst), .out_en(out_en), .ext_sel(rev_ext_sel),
    .pins(rev_pins), .reg_we(rev_reg_we), .reg_d(rev_reg_d),
    .mode_in(mode_in), .rev_nxt(rev_nxt), .rev_q(rev_q), .mode_q(mode_q)
  );

  cfgs_addr_ctl #(.REV_W(REV_W), .OFS_W(OFS_W), .BIT_W(BIT_W)) u_addr (
    .clk(clk), .rst(rst), .out_en(out_en), .active(active),
    .wide(mode_q == MODE_BYTE), .busy(busy), .rev_nxt(rev_nxt),
    .addr_nxt(addr_nxt), .addr_q(addr_q), .bit_q(bit_q),
    .drive_q(drive_q), .casc_q(casc_q)
  );

  // read address is the next position, so rom_q always matches addr_q
  cfgs_rom #(.AW(AW), .DW(DATA_W)) u_rom (
    .clk(clk), .we(rom_we), .waddr(rom_waddr), .wdata(rom_wdata),
    .raddr(addr_nxt), .rdata(rom_q)
  );

  assign shifted = rom_q << bit_q;

  always_comb begin
    dout = '0;
    if (drive_q && !casc_q) begin
      if (mode_q == MODE_BYTE) dout = rom_q;
      else                     dout[0] = shifted[DATA_W-1];
    end
  end
  assign cascade_en = casc_q;

  // R1: quiet unless all enables were high at the previous edge
  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(chip_en && out_en && cfg_req) |-> (dout == '0));
  // R2: serial form uses the lowest line only
  p_serial_line_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SERIAL) |-> (dout[DATA_W-1:1] == '0));
  // R5: an exhausted device stays off the data lines
  p_casc_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    cascade_en |-> (dout == '0));
  // R8: the captured revision selects the region being read
  p_region_r8: assert property (@(posedge clk) disable iff (rst)
    out_en |=> (addr_q[AW-1:OFS_W] == rev_q));
endmodule

// File: tb/sim_cfg_streamer.sv
module sim_cfg_streamer;
  typedef struct packed {
    logic       ext;
    logic [1:0] pins;
    logic [1:0] ireg;
    logic       wide;
    logic [1:0] rev;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{1'b1, 2'd2, 2'd0, 1'b1, 2'd2},
    '{1'b0, 2'd3, 2'd1, 1'b1, 2'd1},
    '{1'b1, 2'd0, 2'd3, 1'b0, 2'd0},
    '{1'b0, 2'd0, 2'd3, 1'b0, 2'd3},
    '{1'b1, 2'd3, 2'd2, 1'b1, 2'd3},
    '{1'b0, 2'd2, 2'd0, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst, chip_en, out_en, cfg_req, busy, byte_mode, rev_ext_sel;
  logic [1:0] rev_pins, rev_reg_d;
  logic rev_reg_we, rom_we;
  logic [5:0] rom_waddr;
  logic [7:0] rom_wdata, dout;
  logic cascade_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_streamer u0 (
    .clk(clk), .rst(rst), .chip_en(chip_en), .out_en(out_en),
    .cfg_req(cfg_req), .busy(busy), .byte_mode(byte_mode),
    .rev_ext_sel(rev_ext_sel), .rev_pins(rev_pins), .rev_reg_we(rev_reg_we),
    .rev_reg_d(rev_reg_d), .rom_we(rom_we), .rom_waddr(rom_waddr),
    .rom_wdata(rom_wdata), .dout(dout), .cascade_en(cascade_en)
  );

  function automatic logic [7:0] img(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  function automatic logic [7:0] ser_bit(input int base, input int i);
    logic [7:0] b;
    b = img(base + i / 8);
    return {7'd0, b[7 - (i % 8)]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // hold out_en low for two edges, then release
  task automatic restart();
    @(negedge clk); out_en = 1'b0;
    @(negedge clk);
    @(negedge clk); out_en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    rst = 1'b1; chip_en = 1'b1; out_en = 1'b0; cfg_req = 1'b1; busy = 1'b0;
    byte_mode = 1'b1; rev_ext_sel = 1'b1; rev_pins = 2'd0; rev_reg_we = 1'b0;
    rev_reg_d = 2'd0; rom_we = 1'b0; rom_waddr = '0; rom_wdata = '0;
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); rom_we = 1'b1; rom_waddr = 6'(a); rom_wdata = img(a);
    end
    @(negedge clk); rom_we = 1'b0; out_en = 1'b1;
    @(negedge clk);
    chk("R6 reset dout", dout, 0);
    chk("R6 reset cascade_en", cascade_en, 0);
    rst = 1'b0;

    // vector table: revision source, revision and form
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      out_en = 1'b0; rev_reg_we = 1'b1; rev_reg_d = VEC[v].ireg;
      rev_ext_sel = VEC[v].ext; rev_pins = VEC[v].pins; byte_mode = VEC[v].wide;
      @(negedge clk); rev_reg_we = 1'b0;
      @(negedge clk); out_en = 1'b1;
      if (VEC[v].wide) begin
        for (int i = 0; i < 16; i++) begin
          @(negedge clk);
          chk("R3 R7 byte stream", dout, img(VEC[v].rev * 16 + i));
          chk("R5 no early cascade", cascade_en, 0);
        end
        @(negedge clk);
        chk("R5 cascade_en raised", cascade_en, 1);
        chk("R5 dout quiet after end", dout, 0);
        @(negedge clk);
        chk("R5 halted", cascade_en, 1);
      end else begin
        for (int i = 0; i < 24; i++) begin
          @(negedge clk);
          chk("R2 R10 R7 serial bit", dout, ser_bit(VEC[v].rev * 16, i));
        end
      end
    end

    // directed: busy stall, revision change, pauses, reset
    rev_ext_sel = 1'b1; rev_pins = 2'd1; byte_mode = 1'b1;
    restart();
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R3 item 2", dout, img(18));
    busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R4 busy holds byte", dout, img(18));
    end
    busy = 1'b0;
    @(negedge clk); chk("R4 resume after busy", dout, img(19));
    rev_pins = 2'd3; byte_mode = 1'b0;
    @(negedge clk); chk("R8 mid-stream change ignored", dout, img(20));
    chip_en = 1'b0;
    @(negedge clk); chk("R1 chip_en low quiet", dout, 0);
    chip_en = 1'b1;
    @(negedge clk); chk("R9 resume same item", dout, img(20));
    @(negedge clk); chk("R9 next item", dout, img(21));
    cfg_req = 1'b0;
    @(negedge clk); chk("R1 cfg_req low quiet", dout, 0);
    cfg_req = 1'b1;
    @(negedge clk); chk("R9 resume after cfg_req", dout, img(21));
    out_en = 1'b0; byte_mode = 1'b1;
    @(negedge clk);
    chk("R6 out_en low dout", dout, 0);
    chk("R6 out_en low cascade_en", cascade_en, 0);
    out_en = 1'b1;
    @(negedge clk); chk("R6 R8 restart in new region", dout, img(48));

    // serial form ignores busy
    rev_pins = 2'd0; byte_mode = 1'b0; busy = 1'b1;
    restart();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); chk("R4 R10 serial ignores busy", dout, ser_bit(0, i));
    end
    busy = 1'b0;

    // synchronous reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    chk("R6 rst dout", dout, 0);
    chk("R6 rst cascade_en", cascade_en, 0);
    rst = 1'b0;
    @(negedge clk); chk("R6 R2 restart after rst", dout, ser_bit(0, 0));
    @(negedge clk);
    finish_run();
  end
endmodule